// File: doc/BRIEF.md
# Two-Path Fault-Tolerant Eight-Port Switching Network

This block is an eight-input, eight-output packet switching fabric built from four ranks of two-by-two elements. The extra rank gives every source–destination pair two routes that touch different elements in the two middle ranks. The route is named by a path digit. Each route meets the other only in the first rank, where it leaves, and in the last rank, where it rejoins. A request carries a 3-bit destination and a valid bit. On each cycle the block picks a path digit for every request, resolves contention rank by rank, and one clock later presents the survivors at their destination ports with the source number and the path digit used.

The source and destination numbers are split into three binary digits. The source is {a2,a1,a0}, with a2 as the MSB. The destination is {b2,b1,b0}, with b2 as the MSB.

- The first rank changes a2 into the path digit p.
- The second rank changes a1 into b1.
- The third rank changes a0 into b0.
- The last rank changes p into b2.

If no fault is known, the path digit is pseudo-random. Software can mark individual routes as broken with a fault mask, and the choice then avoids them. If both routes of a request are masked, the request is reported as unreachable and is not sent into the fabric. If the first and last ranks are healthy, any single broken middle route can be steered around.

Top module: `xs_net`

## Requirements
- R1: While `rst` is high at a clock edge, every output bit (`out_vld`, `out_src`, `out_path`, `unreach`, `blocked`) is zero after that edge. The path generator returns to its seed, 16'hACE1.
- R2: A request presented with `in_vld[i]=1` and `in_dst[i]=d` is reported one clock later in exactly one way: delivered (`out_vld[d]=1`, `out_src[d]=i`), `blocked[i]=1`, or `unreach[i]=1`. A destination port with no delivery shows `out_vld`, `out_src` and `out_path` all zero.
- R3: The path generator is a 16-bit right-shifting register. Each step computes `s' = (s>>1) ^ (s[0] ? 16'hB400 : 0)`. If fault mask bits `2i` (path 0) and `2i+1` (path 1) are both clear, input i uses path digit `s[i] ^ s[i+8]`, taken from the state before the step. The generator steps once on every clock edge at which at least one request is injected.
- R4: If exactly one of mask bits `2i` and `2i+1` is set, input i uses the other path. A delivered output never reports a path whose mask bit was set.
- R5: If both mask bits of a valid input are set, that input's `unreach` is 1 on the next cycle. The request is not injected, takes part in no contention and delivers nothing.
- R6: Two injected requests conflict in a rank when their link state after that rank is equal. The link states are:
  - after rank 1: (p,a1,a0)
  - after rank 2: (p,b1,a0)
  - after rank 3: (p,b1,b0)
  - after rank 4: (b2,b1,b0)

  Ranks are resolved in order. In each rank the lower source number wins over every higher-numbered request still in flight. A loser is dropped and reported as `blocked`.
- R7: Two requests that use different path digits never conflict in the first three ranks. Two such requests with different destinations are both delivered.
- R8: On a clock edge at which no request is injected (none valid, or all unreachable), the path generator holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 8 | Request valid, one bit per source |
| in_dst | input | 8x3 | Destination number per source (packed, element i for source i) |
| fault_mask | input | 16 | Broken-route mask; bit 2i+p marks path p of source i |
| out_vld | output | 8 | Delivery valid per destination port |
| out_src | output | 8x3 | Source number delivered on each destination port |
| out_path | output | 8 | Path digit used by each delivery |
| unreach | output | 8 | Per source: both routes masked, request dropped |
| blocked | output | 8 | Per source: injected but lost contention |

## Verification
The bench uses the default build: three address digits, eight ports and a sixteen-bit path generator. At this size, uniform random destinations and sparse masks often produce the following:
- two requests meeting in each of the four ranks;
- requests with one route masked;
- requests with both routes masked.

The bench therefore exercises fixed-priority resolution in every rank, fault steering, and the rule that the generator holds when nothing is injected. Directed cycles pin down the following cases:
- a single delivery;
- a forced detour;
- a fully masked source;
- two sources on opposite paths sharing a first-rank element;
- a head-on collision at one destination.

// File: rtl/xs_pkg.sv
package xs_pkg;
    localparam int AW          = 3;            // digits per port number
    localparam int NP          = 1 << AW;      // ports
    localparam int NSTG        = AW + 1;       // ranks including the extra one
    localparam int LW          = 2 * NP;       // path generator width
    localparam int MW          = 2 * NP;       // fault mask width (two routes per source)
    localparam logic [LW-1:0] GEN_SEED = 16'hACE1;
    localparam logic [LW-1:0] GEN_TAPS = 16'hB400;

    typedef logic [AW-1:0] port_t;

    typedef struct packed {
        logic  live;
        logic  path;
        port_t src;
        port_t dst;
    } req_t;

    // Link state a request occupies after rank stg (0-based).
    function automatic port_t link_state(input req_t q, input int stg);
        case (stg)
            0:       return {q.path, q.src[1], q.src[0]};
            1:       return {q.path, q.dst[1], q.src[0]};
            2:       return {q.path, q.dst[1], q.dst[0]};
            default: return q.dst;
        endcase
    endfunction
endpackage

// File: rtl/xs_gen.sv
module xs_gen
    import xs_pkg::*;
#(
    parameter int              W    = LW,
    parameter logic [W-1:0]    SEED = GEN_SEED,
    parameter logic [W-1:0]    TAPS = GEN_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (step)
            state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
    end
endmodule

// File: rtl/xs_pick.sv
module xs_pick
    import xs_pkg::*;
(
    input  logic [NP-1:0]         vld,
    input  port_t [NP-1:0]        dst,
    input  logic [MW-1:0]         mask,
    input  logic [LW-1:0]         rnd,
    output req_t [NP-1:0]         req,
    output logic [NP-1:0]         dead
);
    for (genvar i = 0; i < NP; i++) begin : g_src
        logic ok0, ok1, coin;
        assign ok0  = !mask[2*i];
        assign ok1  = !mask[2*i+1];
        assign coin = rnd[i] ^ rnd[i+NP];
        assign req[i].live = vld[i] && (ok0 || ok1);
        assign req[i].path = (ok0 && ok1) ? coin : ok1;
        assign req[i].src  = port_t'(i);
        assign req[i].dst  = dst[i];
        assign dead[i]     = vld[i] && !ok0 && !ok1;
    end
endmodule

// File: rtl/xs_rank.sv
module xs_rank
    import xs_pkg::*;
#(
    parameter int STG = 0
) (
    input  req_t [NP-1:0] req_i,
    output req_t [NP-1:0] req_o
);
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < NP; j++) begin
                if (j < i && req_i[j].live &&
                    link_state(req_i[j], STG) == link_state(req_i[i], STG))
                    beaten = 1'b1;
            end
            req_o[i]      = req_i[i];
            req_o[i].live = req_i[i].live && !beaten;
        end
    end
endmodule

// File: rtl/xs_net.sv
module xs_net
    import xs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NP-1:0]         in_vld,
    input  logic [NP-1:0][AW-1:0] in_dst,
    input  logic [MW-1:0]         fault_mask,
    output logic [NP-1:0]         out_vld,
    output logic [NP-1:0][AW-1:0] out_src,
    output logic [NP-1:0]         out_path,
    output logic [NP-1:0]         unreach,
    output logic [NP-1:0]         blocked
);
    logic [LW-1:0] lfsr_q;
    logic          any_inj;
    logic [NP-1:0] dead;
    req_t [NP-1:0] chain [0:NSTG];

    logic [NP-1:0]         vld_n, path_n, blk_n;
    logic [NP-1:0][AW-1:0] src_n;

    xs_gen u_gen (
        .clk   (clk),
        .rst   (rst),
        .step  (any_inj),
        .state (lfsr_q)
    );

    xs_pick u_pick (
        .vld  (in_vld),
        .dst  (in_dst),
        .mask (fault_mask),
        .rnd  (lfsr_q),
        .req  (chain[0]),
        .dead (dead)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_rank
        xs_rank #(.STG(s)) u_rank (
            .req_i (chain[s]),
            .req_o (chain[s+1])
        );
    end

    always_comb begin
        any_inj = 1'b0;
        vld_n   = '0;
        src_n   = '0;
        path_n  = '0;
        blk_n   = '0;
        for (int i = 0; i < NP; i++) begin
            any_inj  = any_inj | chain[0][i].live;
            blk_n[i] = chain[0][i].live && !chain[NSTG][i].live;
            if (chain[NSTG][i].live) begin
                vld_n[chain[NSTG][i].dst]  = 1'b1;
                src_n[chain[NSTG][i].dst]  = chain[NSTG][i].src;
                path_n[chain[NSTG][i].dst] = chain[NSTG][i].path;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= '0;
            out_src  <= '0;
            out_path <= '0;
            unreach  <= '0;
            blocked  <= '0;
        end else begin
            out_vld  <= vld_n;
            out_src  <= src_n;
            out_path <= path_n;
            unreach  <= dead;
            blocked  <= blk_n;
        end
    end
endmodule

// File: rtl/xs_net_chk.sv
module xs_net_chk
    import xs_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NP-1:0]         in_vld,
    input logic [MW-1:0]         fault_mask,
    input logic [NP-1:0]         out_vld,
    input logic [NP-1:0][AW-1:0] out_src,
    input logic [NP-1:0]         out_path,
    input logic [NP-1:0]         unreach,
    input logic [NP-1:0]         blocked,
    input logic [LW-1:0]         lfsr_q,
    input logic                  any_inj
);
    logic [MW-1:0] mask_d;
    always_ff @(posedge clk) mask_d <= fault_mask;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_vld == '0 && unreach == '0 && blocked == '0 && out_path == '0));

    assert_every_request_accounted_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_vld) + $countones(unreach) + $countones(blocked))
                 == $past($countones(in_vld)));

    assert_gen_steps_R3: assert property (@(posedge clk) disable iff (rst)
        any_inj |=> lfsr_q != $past(lfsr_q));

    assert_gen_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !any_inj |=> $stable(lfsr_q));

    assert_blocked_not_unreach_R6: assert property (@(posedge clk) disable iff (rst)
        (blocked & unreach) == '0);

    for (genvar i = 0; i < NP; i++) begin : g_chk
        assert_fully_masked_R5: assert property (@(posedge clk) disable iff (rst)
            (in_vld[i] && fault_mask[2*i] && fault_mask[2*i+1]) |=> (unreach[i] && !blocked[i]));

        assert_no_masked_route_R4: assert property (@(posedge clk) disable iff (rst)
            out_vld[i] |-> !mask_d[{out_src[i], out_path[i]}]);
    end
endmodule

bind xs_net xs_net_chk u_chk (.*);

// File: tb/sim_xs_net.sv
`timescale 1ns/1ps
module sim_xs_net;
    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       in_vld;
    logic [7:0][2:0]  in_dst;
    logic [15:0]      fault_mask;
    logic [7:0]       out_vld;
    logic [7:0][2:0]  out_src;
    logic [7:0]       out_path;
    logic [7:0]       unreach;
    logic [7:0]       blocked;

    int checks = 0;
    int failures = 0;
    int m_gen;
    logic [7:0]      e_vld, e_path, e_unr, e_blk;
    logic [7:0][2:0] e_src;

    always #2.5 clk = ~clk;

    xs_net u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int link(int s, int i, int d, int r);
        int n2 = (i >> 1) & 1, n3 = i & 1, m2 = (d >> 1) & 1, m3 = d & 1;
        case (s)
            0: return r*4 + n2*2 + n3;
            1: return r*4 + m2*2 + n3;
            2: return r*4 + m2*2 + m3;
            default: return d;
        endcase
    endfunction

    // Reference model: compute expectations for the current inputs, advance generator.
    task automatic model();
        int live[8], rr[8], nl[8];
        bit inj = 0;
        e_vld = 0; e_src = 0; e_path = 0; e_unr = 0; e_blk = 0;
        for (int i = 0; i < 8; i++) begin
            bit ok0 = !fault_mask[2*i], ok1 = !fault_mask[2*i+1];
            live[i] = in_vld[i] && (ok0 || ok1);
            rr[i]   = (ok0 && ok1) ? (((m_gen >> i) ^ (m_gen >> (i+8))) & 1) : int'(ok1);
            if (in_vld[i] && !ok0 && !ok1) e_unr[i] = 1;
            if (live[i] != 0) inj = 1;
        end
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 8; i++) begin
                nl[i] = live[i];
                for (int j = 0; j < i; j++)
                    if (live[j] != 0 && live[i] != 0 &&
                        link(s, j, in_dst[j], rr[j]) == link(s, i, in_dst[i], rr[i]))
                        nl[i] = 0;
            end
            for (int i = 0; i < 8; i++) begin
                if (live[i] != 0 && nl[i] == 0) e_blk[i] = 1;
                live[i] = nl[i];
            end
        end
        for (int i = 0; i < 8; i++)
            if (live[i] != 0) begin
                e_vld[in_dst[i]]  = 1;
                e_src[in_dst[i]]  = 3'(i);
                e_path[in_dst[i]] = rr[i][0];
            end
        if (inj) m_gen = (m_gen >> 1) ^ (((m_gen & 1) != 0) ? 'hB400 : 0);
    endtask

    // Called at a falling edge: apply inputs, run one clock, compare at next falling edge.
    task automatic cycle(input logic [7:0] v, input logic [7:0][2:0] d, input logic [15:0] m);
        in_vld = v; in_dst = d; fault_mask = m;
        model();
        @(posedge clk);
        @(negedge clk);
        check(out_vld == e_vld && out_src == e_src, "R2 delivery", {out_vld, out_src}, {e_vld, e_src});
        check(out_path == e_path, "R3 path digit", out_path, e_path);
        check(unreach == e_unr, "R5 unreachable", unreach, e_unr);
        check(blocked == e_blk, "R6 blocked", blocked, e_blk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0][2:0] d;
        rst = 1; in_vld = 0; in_dst = 0; fault_mask = 0;
        m_gen = 'hACE1;
        repeat (3) @(negedge clk);
        rst = 0;
        check({out_vld, out_path, unreach, blocked} == 0 && out_src == 0, "R1 reset state",
              {out_vld, out_path, unreach, blocked}, 0);

        // idle cycles: generator must hold (R8, via later path digits)
        d = 0;
        cycle(8'h00, d, 16'h0000);
        cycle(8'h00, d, 16'h0000);

        // lone request 5 -> 2 (R2, R3)
        d = 0; d[5] = 3'd2;
        cycle(8'h20, d, 16'h0000);
        check(out_vld == 8'h04 && out_src[2] == 3'd5, "R2 lone delivery", {out_vld, out_src[2]}, {8'h04, 3'd5});

        // input 3 -> 6 with path 0 broken (R4)
        d = 0; d[3] = 3'd6;
        cycle(8'h08, d, 16'h0040);
        check(out_vld[6] && out_src[6] == 3'd3 && out_path[6] == 1'b1, "R4 detour to path 1",
              {out_vld[6], out_src[6], out_path[6]}, {1'b1, 3'd3, 1'b1});

        // input 2 both routes broken (R5), nothing injected so generator holds (R8)
        d = 0; d[2] = 3'd1;
        cycle(8'h04, d, 16'h0030);
        check(unreach == 8'h04 && out_vld == 8'h00, "R5 both routes masked", {unreach, out_vld}, {8'h04, 8'h00});
        d = 0; d[0] = 3'd0;
        cycle(8'h01, d, 16'h0000);
        check(out_path[0] == e_path[0], "R8 generator held over idle cycle", out_path[0], e_path[0]);

        // opposite paths sharing the first-rank element: both delivered (R7)
        d = 0; d[0] = 3'd0; d[4] = 3'd4;
        cycle(8'h11, d, 16'h0102);
        check(out_vld == 8'h11 && blocked == 8'h00, "R7 disjoint paths both delivered",
              {out_vld, blocked}, {8'h11, 8'h00});

        // same path, same first-rank element: lower source wins (R6)
        d = 0; d[0] = 3'd0; d[4] = 3'd4;
        cycle(8'h11, d, 16'h0202);
        check(out_vld == 8'h01 && blocked == 8'h10, "R6 first-rank conflict", {out_vld, blocked}, {8'h01, 8'h10});

        // head-on collision at destination 7 (R6)
        d = 0; d[1] = 3'd7; d[6] = 3'd7;
        cycle(8'h42, d, 16'h0000);
        check(out_vld[7] && out_src[7] == 3'd1 && blocked == 8'h40, "R6 lower source wins",
              {out_vld[7], out_src[7], blocked}, {1'b1, 3'd1, 8'h40});

        // full identity permutation
        for (int i = 0; i < 8; i++) d[i] = 3'(i);
        cycle(8'hFF, d, 16'h0000);

        // random traffic with sparse faults
        for (int n = 0; n < 600; n++) begin
            logic [15:0] m = 0;
            for (int i = 0; i < 8; i++) d[i] = 3'($urandom_range(0, 7));
            for (int b = 0; b < 16; b++) m[b] = ($urandom_range(0, 7) == 0);
            cycle(8'($urandom), d, m);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule